// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder Back End for a Flash Converter

This block is the digital half of a flash analog-to-digital converter. A bank of comparators presents a thermometer vector, one bit per comparator, and the block turns it into a straight-binary code with a separate over-range flag. The vector seen at one rising clock edge is captured into a sample register. This stands for the end of the low (sampling) phase, during which the comparators settle. That sample is reduced to a code by counting its ones. The code is loaded into an output register on the following rising edge. A conversion therefore spans high, low and high clock phases. In continuous operation a new result appears on every clock, while the next sample is already being taken.

The output register feeds two groups of gated outputs, the code bits and the over-range flag. Two enable inputs control them. In place of real high-impedance drivers, each group has an output-enable signal. An internal drive-mode decode (none, flag only, full) sets both enables from the two inputs. The block uses a single clock and an active-low synchronous reset.

Top module: `tce_backend`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, `code_o` becomes 0 and `ovf_o` becomes 0 after that edge, including when a full-scale vector was being converted.
- R2: For a vector with n ones and n at most 127, `code_o` equals n in straight binary with `code_o[6]` as the most significant bit, and `ovf_o` is 0. For example, 32 gives 0x20, 63 gives 0x3F and 64 gives 0x40.
- R3: With all 128 comparator bits set, `ovf_o` is 1 and `code_o` is 127, so the word {`ovf_o`, `code_o`} reads 0xFF. Over-range never clears the code bits.
- R4: With exactly 127 bits set, `code_o` is 127 and `ovf_o` stays 0. This is the boundary just below over-range.
- R5: A vector held on `therm_i` at rising edge k appears on `code_o`/`ovf_o` after rising edge k+1. Vectors that change every cycle give one result per cycle, in order.
- R6: `code_oe_o` is 1 only when `en_code_i` and `en_all_i` are both 1.
- R7: `ovf_oe_o` follows `en_all_i` whatever the value of `en_code_i`.
- R8: A vector whose ones are not contiguous (a bubble pattern) encodes as its total number of ones. No bubble correction is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; high is auto-zero, low is sampling |
| rst_n | input | 1 | Active-low synchronous reset |
| therm_i | input | 128 | Comparator outputs, bit i set when comparator i has tripped |
| en_code_i | input | 1 | Enable that gates the code bits only |
| en_all_i | input | 1 | Enable that gates the code bits and the flag |
| code_o | output | 7 | Encoded result, straight binary, bit 6 most significant |
| ovf_o | output | 1 | Over-range flag, all comparators tripped |
| code_oe_o | output | 1 | Drive enable of the code bits (0 stands for high impedance) |
| ovf_oe_o | output | 1 | Drive enable of the flag (0 stands for high impedance) |

## Verification
The bench builds the block with its default of 128 comparators and a 7-bit code. At this size every fill level from empty to full (129 cases) can be swept, so both saturation edges (127 and 128 ones) and the mid-scale carry are all reached. Bubble patterns, a back-to-back stream that tests per-cycle throughput and latency, a reset in mid-stream and all four enable combinations complete the picture.

// File: rtl/tce_pkg.sv
package tce_pkg;

    // Drive state of the gated output groups
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,   // both groups released
        DRV_FLAG = 2'd1,   // only the over-range flag driven
        DRV_FULL = 2'd2    // code bits and flag driven
    } drive_e;

    function automatic drive_e drive_mode(input logic en_code, input logic en_all);
        if (!en_all)  return DRV_NONE;
        if (!en_code) return DRV_FLAG;
        return DRV_FULL;
    endfunction

endpackage

// File: rtl/tce_sample_stage.sv
module tce_sample_stage #(
    parameter int NUM_CMP = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] therm_i,
    output logic [NUM_CMP-1:0] therm_q
);

    // Closes the sampling window at the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) therm_q <= '0;
        else        therm_q <= therm_i;
    end

endmodule

// File: rtl/tce_ones_encoder.sv
module tce_ones_encoder #(
    parameter int NUM_CMP = 128,
    parameter int CODE_W  = $clog2(NUM_CMP)
) (
    input  logic [NUM_CMP-1:0] vec_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               ovf_o
);

    localparam int CNT_W    = $clog2(NUM_CMP + 1);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] psum [0:NUM_CMP];
    logic             sat;

    assign psum[0] = '0;

    // Running ones count along the comparator bank
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cnt
        assign psum[g+1] = psum[g] + CNT_W'(vec_i[g]);
    end

    assign ovf_o  = (psum[NUM_CMP] == CNT_W'(NUM_CMP));
    assign sat    = (psum[NUM_CMP] >  CNT_W'(CODE_MAX));
    assign code_o = sat ? CODE_W'(CODE_MAX) : psum[NUM_CMP][CODE_W-1:0];

endmodule

// File: rtl/tce_out_stage.sv
module tce_out_stage
    import tce_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ovf_i,
    input  logic              en_code_i,
    input  logic              en_all_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ovf_o,
    output logic              code_oe_o,
    output logic              ovf_oe_o
);

    drive_e mode;

    // Output register, loaded as the clock returns high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            ovf_o  <= 1'b0;
        end else begin
            code_o <= code_i;
            ovf_o  <= ovf_i;
        end
    end

    assign mode = drive_mode(en_code_i, en_all_i);

    always_comb begin
        unique case (mode)
            DRV_NONE: begin code_oe_o = 1'b0; ovf_oe_o = 1'b0; end
            DRV_FLAG: begin code_oe_o = 1'b0; ovf_oe_o = 1'b1; end
            DRV_FULL: begin code_oe_o = 1'b1; ovf_oe_o = 1'b1; end
            default:  begin code_oe_o = 1'b0; ovf_oe_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tce_backend.sv
module tce_backend #(
    parameter int NUM_CMP = 128,
    parameter int CODE_W  = $clog2(NUM_CMP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] therm_i,
    input  logic               en_code_i,
    input  logic               en_all_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               ovf_o,
    output logic               code_oe_o,
    output logic               ovf_oe_o
);

    logic [NUM_CMP-1:0] smp_q;
    logic [CODE_W-1:0]  enc_code;
    logic               enc_ovf;

    tce_sample_stage #(.NUM_CMP(NUM_CMP)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .therm_i (therm_i),
        .therm_q (smp_q)
    );

    tce_ones_encoder #(.NUM_CMP(NUM_CMP), .CODE_W(CODE_W)) u_enc (
        .vec_i  (smp_q),
        .code_o (enc_code),
        .ovf_o  (enc_ovf)
    );

    tce_out_stage #(.CODE_W(CODE_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (enc_code),
        .ovf_i     (enc_ovf),
        .en_code_i (en_code_i),
        .en_all_i  (en_all_i),
        .code_o    (code_o),
        .ovf_o     (ovf_o),
        .code_oe_o (code_oe_o),
        .ovf_oe_o  (ovf_oe_o)
    );

endmodule

// File: rtl/tce_backend_chk.sv
module tce_backend_chk #(
    parameter int NUM_CMP = 128,
    parameter int CODE_W  = $clog2(NUM_CMP)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CMP-1:0] therm_i,
    input logic               en_code_i,
    input logic               en_all_i,
    input logic [CODE_W-1:0]  code_o,
    input logic               ovf_o,
    input logic               code_oe_o,
    input logic               ovf_oe_o
);

    localparam int CODE_MAX = (1 << CODE_W) - 1;

    logic [1:0] warm;

    // Edges seen with reset released, saturating at 2
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    function automatic logic [CODE_W-1:0] expect_code(input logic [NUM_CMP-1:0] v);
        int n;
        n = $countones(v);
        if (n > CODE_MAX) n = CODE_MAX;
        return CODE_W'(n);
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0) && !ovf_o);

    // R3
    ovf_full_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (code_o == CODE_W'(CODE_MAX)));

    // R5
    code_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (code_o == expect_code($past(therm_i, 2))));

    // R3
    ovf_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (ovf_o == (&$past(therm_i, 2))));

    // R6
    code_oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_code_i && en_all_i) |-> code_oe_o);

    // R6
    code_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_oe_o |-> (en_code_i && en_all_i));

    // R7
    ovf_oe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all_i && !en_code_i) |-> (ovf_oe_o && !code_oe_o));

    // R7
    ovf_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_all_i |-> (!ovf_oe_o && !code_oe_o));

endmodule

bind tce_backend tce_backend_chk #(.NUM_CMP(NUM_CMP), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .therm_i   (therm_i),
    .en_code_i (en_code_i),
    .en_all_i  (en_all_i),
    .code_o    (code_o),
    .ovf_o     (ovf_o),
    .code_oe_o (code_oe_o),
    .ovf_oe_o  (ovf_oe_o)
);

// File: tb/tce_backend_tb.sv
module tce_backend_tb;

    localparam int NUM = 128;
    localparam int CW  = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NUM-1:0] therm_i = '0;
    logic           en_code_i = 1'b1;
    logic           en_all_i = 1'b1;
    logic [CW-1:0]  code_o;
    logic           ovf_o;
    logic           code_oe_o;
    logic           ovf_oe_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tce_backend u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .therm_i   (therm_i),
        .en_code_i (en_code_i),
        .en_all_i  (en_all_i),
        .code_o    (code_o),
        .ovf_o     (ovf_o),
        .code_oe_o (code_oe_o),
        .ovf_oe_o  (ovf_oe_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int n);
        return (n > 127) ? 127 : n;
    endfunction

    function automatic logic [NUM-1:0] fill(input int n);
        logic [NUM-1:0] ones;
        ones = '1;
        return (n == 0) ? '0 : (ones >> (NUM - n));
    endfunction

    // Apply one vector, then check two rising edges later
    task automatic convert(input logic [NUM-1:0] v, input string req);
        int n;
        n = $countones(v);
        @(negedge clk);
        therm_i = v;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(int'(code_o) == exp_code(n), req, int'(code_o), exp_code(n));
        chk(ovf_o == (n == NUM), req, int'(ovf_o), int'(n == NUM));
    endtask

    initial begin
        logic [NUM-1:0] stream [4];

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(code_o == '0, "R1", int'(code_o), 0);
        chk(ovf_o == 1'b0, "R1", int'(ovf_o), 0);
        rst_n = 1'b1;

        // R2 R3 R4: every fill level 0..128
        for (int n = 0; n <= NUM; n++) begin
            if (n == NUM)          convert(fill(n), "R3");
            else if (n == NUM - 1) convert(fill(n), "R4");
            else                   convert(fill(n), "R2");
        end

        // R2 named mid-scale and quarter-scale points
        convert(fill(32), "R2");
        chk(code_o == 7'h20, "R2", int'(code_o), 32);
        convert(fill(63), "R2");
        chk(code_o == 7'h3F, "R2", int'(code_o), 63);
        convert(fill(64), "R2");
        chk(code_o == 7'h40, "R2", int'(code_o), 64);

        // R3 over-range word reads 0xFF
        convert('1, "R3");
        chk({ovf_o, code_o} == 8'hFF, "R3", int'({ovf_o, code_o}), 255);

        // R8 bubble patterns
        convert({16{8'b0001_0011}}, "R8");
        convert(128'h8000_0000_0000_0000_0000_0000_0000_0001, "R8");
        convert(128'hFFFF_FFFF_0000_0000_FFFF_FFFF_FFFF_FFFE, "R8");
        convert({64{2'b01}}, "R8");

        // R5 back-to-back stream, one result per cycle
        stream[0] = fill(5);
        stream[1] = fill(90);
        stream[2] = '1;
        stream[3] = fill(17);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int n;
                n = $countones(stream[i-2]);
                chk(int'(code_o) == exp_code(n), "R5", int'(code_o), exp_code(n));
                chk(ovf_o == (n == NUM), "R5", int'(ovf_o), int'(n == NUM));
            end
            if (i < 4) therm_i = stream[i];
        end

        // R6 R7 enable combinations
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            en_code_i = c[0];
            en_all_i  = c[1];
            #1;
            chk(code_oe_o == (c[0] & c[1]), "R6", int'(code_oe_o), int'(c[0] & c[1]));
            chk(ovf_oe_o == c[1], "R7", int'(ovf_oe_o), int'(c[1]));
        end

        // R1 reset in mid-stream with a full-scale vector
        convert('1, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(code_o == '0, "R1", int'(code_o), 0);
        chk(ovf_o == 1'b0, "R1", int'(ovf_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule